// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide I/O window of four ports. Each of the first three ports is the data port of one counter. The fourth port is a write-only command port. A command byte selects a counter and sets four things for it: how its count is moved over the byte bus, its waveform mode, and whether it counts in binary or in four-digit BCD. A command byte can instead ask for a snapshot of the running count.

All counters advance on a shared count-enable strobe, `tick_i`, which pulses for one clock cycle. Each counter drives one waveform output. A halt request freezes every counter while halting is enabled.

Four modes are built:
- terminal-count flag
- periodic rate pulse
- square wave
- single software strobe

Command bytes that ask for the gate-driven modes are dropped. So is the read-back command.

Top module: `pit_timer`

## Requirements
- R1: Port address 0, 1 and 2 access counters 0, 1 and 2 respectively. Address 3 is the command port. A read at address 3 returns 00h.
- R2: Command bits [7:6] pick the target counter (00, 01, 10 for counters 0, 1, 2). The value 11 is the read-back command, and it changes no counter's state or output.
- R3: Command bits [5:4] set the access pattern:
  - 01: low byte only. The other byte is zero on write.
  - 10: high byte only.
  - 11: low byte, then high byte, with separate read and write byte pointers.

  Any command other than a latch resets both pointers of its counter to the low byte.
- R4: Access code 00 is a latch command. It copies the count into a hold register, and data reads return the held value until the configured byte(s) have been read. A latch command issued while a held value is still unread is ignored.
- R5: Command bits [3:1] give the mode: 000 terminal flag, 010 rate, 011 square, 100 strobe. Code 110 acts as 010, and 111 acts as 011. A command with code 001 or 101 is ignored entirely.
- R6: Command bit 0 set selects BCD counting (9999 follows 0000). Bit 0 clear selects binary counting (FFFFh follows 0000h). A loaded value of 0 is the largest count.
- R7: After reset every counter is in mode 0, binary, access code 00, with count 0 and output low. A data read returns 00h.
- R8: While `halt_en_i` and `halt_req_i` are both high, ticks are ignored: counts, pending loads and outputs hold.
- R9: A count write takes effect on the first tick after its final byte. Until that tick the counter keeps its previous value.
- R10: A command write sets the output low for mode 0 and high for the other modes. In mode 0 the output stays low after the load and goes high on the tick that moves the count from 1 to 0.
- R11: Mode 2 with reload value N: the output is low for one tick while the count is 1, and the count then reloads N. The pattern per N ticks is N-1 high, 1 low.
- R12: Mode 3 with reload value N: the output is high while the count is above floor(N/2) and low otherwise. An odd N gives the high half one extra tick.
- R13: Mode 4: the output goes low for exactly one tick when the count leaves 1, once per load, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Shared count-enable strobe |
| halt_en_i | input | 1 | Halt enable |
| halt_req_i | input | 1 | Halt request |
| wr_i | input | 1 | Port write strobe |
| rd_i | input | 1 | Port read strobe (advances read pointer) |
| addr_i | input | 2 | Port address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| out_o | output | 3 | Counter waveform outputs |

## Verification
Each mode is driven with short reload values so that whole periods can be compared tick by tick against sequences derived from the requirements. Mode 3 is run with both odd and even values to show the extra high tick. Count readback is tried after:
- loads with no tick, which separates a load that waits for a tick from one that takes effect at once
- a latch taken while counting
- a second latch, which must be ignored
- BCD and binary underflow from zero

Illegal, read-back and folded command codes are sent to running counters, and halt is exercised with each of its two inputs alone and with both together.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    M_TERM = 3'd0,
    M_RATE = 3'd2,
    M_SQR  = 3'd3,
    M_STRB = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    RW_LATCH = 2'd0,
    RW_LO    = 2'd1,
    RW_HI    = 2'd2,
    RW_LOHI  = 2'd3
  } rw_e;

  typedef struct packed {
    mode_e mode;
    rw_e   rw;
    logic  bcd;
  } cfg_t;

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) r = v - 1'b1;
    else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[d*4+:4] == 4'd0) r[d*4+:4] = 4'd9;
          else begin
            r[d*4+:4] = v[d*4+:4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    cnt_dec = r;
  endfunction

  // half of the full count, 0 meaning the maximum count
  function automatic logic [CNT_W-1:0] cnt_half(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic [4:0] t;
    logic c;
    r = '0;
    c = 1'b0;
    if (v == '0) r = bcd ? 16'h5000 : 16'h8000;
    else if (!bcd) r = v >> 1;
    else begin
      for (int d = DIGITS - 1; d >= 0; d--) begin
        t = {1'b0, v[d*4+:4]} + (c ? 5'd10 : 5'd0);
        r[d*4+:4] = t[4:1];
        c = t[0];
      end
    end
    cnt_half = r;
  endfunction

  function automatic logic digits_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) if (v[d*4+:4] > 4'd9) ok = 1'b0;
    digits_ok = ok;
  endfunction
endpackage

// File: rtl/pit_cmd_dec.sv
module pit_cmd_dec
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [NUM_CH-1:0] cfg_we_o,
  output logic [NUM_CH-1:0] latch_we_o,
  output logic [NUM_CH-1:0] data_wr_o
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

  logic cmd_wr, legal;
  logic [1:0] sel;

  assign cmd_wr = wr_i && (addr_i == CMD_ADDR);
  assign sel    = wdata_i[7:6];

  always_comb begin
    legal      = 1'b1;
    cfg_o.rw   = rw_e'(wdata_i[5:4]);
    cfg_o.bcd  = wdata_i[0];
    case (wdata_i[3:1])
      3'd0:       cfg_o.mode = M_TERM;
      3'd2, 3'd6: cfg_o.mode = M_RATE;
      3'd3, 3'd7: cfg_o.mode = M_SQR;
      3'd4:       cfg_o.mode = M_STRB;
      default: begin
        cfg_o.mode = M_TERM;
        legal      = 1'b0;
      end
    endcase
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    logic hit;
    assign hit           = cmd_wr && (sel == 2'(i));
    assign latch_we_o[i] = hit && (wdata_i[5:4] == 2'd0);
    assign cfg_we_o[i]   = hit && (wdata_i[5:4] != 2'd0) && legal;
    assign data_wr_o[i]  = wr_i && (addr_i == ADDR_W'(i));
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we_o | latch_we_o)); // R2
  AST_RDBACK_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && sel == 2'd3) |-> (cfg_we_o == '0 && latch_we_o == '0)); // R2
  AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && (wdata_i[3:1] == 3'd1 || wdata_i[3:1] == 3'd5)) |-> cfg_we_o == '0); // R5
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              cfg_we_i,
  input  cfg_t              cfg_i,
  input  logic              latch_we_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);
  cfg_t              cfg_q;
  logic [CNT_W-1:0]  cnt_q, rel_q, load_q, lat_q;
  logic [BYTE_W-1:0] lo_q;
  logic pend_q, run_q, armed_q, out_q, wptr_q, rptr_q, lat_v_q;

  logic [CNT_W-1:0] cnt_nx, half_n, sq_nx, src;
  logic hi_sel;

  always_comb begin
    cnt_nx = cnt_dec(cnt_q, cfg_q.bcd);
    half_n = cnt_half(rel_q, cfg_q.bcd);
    sq_nx  = (cnt_q == 16'd1) ? rel_q : cnt_nx;
    src    = lat_v_q ? lat_q : cnt_q;
    hi_sel = (cfg_q.rw == RW_HI) || (cfg_q.rw == RW_LOHI && rptr_q);
  end

  assign rdata_o = hi_sel ? src[15:8] : src[7:0];
  assign out_o   = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{mode: M_TERM, rw: RW_LATCH, bcd: 1'b0};
      cnt_q   <= '0;
      rel_q   <= '0;
      load_q  <= '0;
      lat_q   <= '0;
      lo_q    <= '0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      lat_v_q <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_q   <= cfg_i;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      lat_v_q <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= (cfg_i.mode != M_TERM);
    end else begin
      if (step_i) begin
        if (pend_q) begin
          cnt_q   <= load_q;
          rel_q   <= load_q;
          pend_q  <= 1'b0;
          run_q   <= 1'b1;
          armed_q <= 1'b1;
          out_q   <= (cfg_q.mode != M_TERM);
        end else if (run_q) begin
          case (cfg_q.mode)
            M_TERM: begin
              cnt_q <= cnt_nx;
              if (armed_q && cnt_q == 16'd1) begin
                out_q   <= 1'b1;
                armed_q <= 1'b0;
              end
            end
            M_RATE: begin
              if (cnt_q == 16'd1) begin
                cnt_q <= rel_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= cnt_nx;
                out_q <= (cnt_nx != 16'd1);
              end
            end
            M_SQR: begin
              cnt_q <= sq_nx;
              out_q <= (sq_nx == '0) || (sq_nx > half_n);
            end
            default: begin
              cnt_q <= cnt_nx;
              out_q <= !(armed_q && cnt_q == 16'd1);
              if (cnt_q == 16'd1) armed_q <= 1'b0;
            end
          endcase
        end
      end
      if (wr_i) begin
        case (cfg_q.rw)
          RW_LO: begin
            load_q <= {8'h00, wdata_i};
            pend_q <= 1'b1;
          end
          RW_HI: begin
            load_q <= {wdata_i, 8'h00};
            pend_q <= 1'b1;
          end
          RW_LOHI: begin
            if (!wptr_q) begin
              lo_q   <= wdata_i;
              wptr_q <= 1'b1;
            end else begin
              load_q <= {wdata_i, lo_q};
              pend_q <= 1'b1;
              wptr_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_i) begin
        if (cfg_q.rw == RW_LOHI) begin
          rptr_q <= ~rptr_q;
          if (rptr_q) lat_v_q <= 1'b0;
        end else lat_v_q <= 1'b0;
      end
      if (latch_we_i && !lat_v_q) begin
        lat_q   <= cnt_q;
        lat_v_q <= 1'b1;
      end
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cfg_we_i) |=> ($stable(cnt_q) && $stable(out_q))); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.mode inside {M_TERM, M_RATE, M_SQR, M_STRB}); // R5
  AST_CFG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_i.mode == M_TERM) |=> !out_q); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_v_q && !rd_i && !cfg_we_i) |=> (lat_v_q && $stable(lat_q))); // R4
  AST_RATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cfg_q.mode == M_RATE && !out_q) |-> cnt_q == 16'd1); // R11
  AST_BCD_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.bcd && run_q && step_i && !pend_q && !cfg_we_i && digits_ok(cnt_q) && digits_ok(rel_q))
      |=> digits_ok(cnt_q)); // R6
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              halt_en_i,
  input  logic              halt_req_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] out_o
);
  cfg_t              cfg;
  logic [NUM_CH-1:0] cfg_we, latch_we, data_wr;
  logic [BYTE_W-1:0] ch_rd [NUM_CH];
  logic              step;

  assign step = tick_i && !(halt_en_i && halt_req_i);

  pit_cmd_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cfg_o     (cfg),
    .cfg_we_o  (cfg_we),
    .latch_we_o(latch_we),
    .data_wr_o (data_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step),
      .cfg_we_i  (cfg_we[i]),
      .cfg_i     (cfg),
      .latch_we_i(latch_we[i]),
      .wr_i      (data_wr[i]),
      .rd_i      (rd_i && (addr_i == ADDR_W'(i))),
      .wdata_i   (wdata_i),
      .rdata_o   (ch_rd[i]),
      .out_o     (out_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) if (addr_i == ADDR_W'(i)) rdata_o = ch_rd[i];
  end

  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(NUM_CH)) |-> rdata_o == '0); // R1
endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, h_en = 1'b0, h_req = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [2:0] outs;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pit_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_en_i(h_en), .halt_req_i(h_req),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .out_o(outs)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    io_rd(a, lo);
    io_rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // pat written left to right = expected output after tick 1..n
  task automatic tick_seq(input string req, input int ch, input int n, input logic [15:0] pat);
    for (int i = 0; i < n; i++) begin
      do_tick();
      chk(req, 16'(outs[ch]), 16'(pat[n-1-i]));
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 outputs", 16'(outs), 16'h0);
    io_rd(2'd0, d); chk("R7 count read", 16'(d), 16'h0);
    io_rd(2'd3, d); chk("R1 cmd port read", 16'(d), 16'h0);
  endtask

  task automatic t_mode0();
    io_wr(2'd3, 8'h30);
    chk("R10 cmd sets low", 16'(outs[0]), 16'h0);
    io_wr(2'd0, 8'h03); io_wr(2'd0, 8'h00);
    tick_seq("R10 mode0 wave", 0, 5, 16'b00011);
  endtask

  task automatic t_load_wait();
    logic [15:0] v;
    io_wr(2'd3, 8'h30);
    io_wr(2'd0, 8'h34); io_wr(2'd0, 8'h12);
    rd16(2'd0, v); chk("R9 no load before tick", v, 16'hFFFF);
    do_tick();
    rd16(2'd0, v); chk("R9 load on tick", v, 16'h1234);
    do_tick();
    rd16(2'd0, v); chk("R9 counting", v, 16'h1233);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    io_wr(2'd3, 8'h00);
    repeat (3) do_tick();
    rd16(2'd0, v); chk("R4 latched value", v, 16'h1233);
    do_tick();
    io_wr(2'd3, 8'h00);
    do_tick();
    io_wr(2'd3, 8'h00);
    rd16(2'd0, v); chk("R4 second latch ignored", v, 16'h122F);
    rd16(2'd0, v); chk("R4 live after read", v, 16'h122E);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    logic [15:0] v;
    io_wr(2'd3, 8'h54); io_wr(2'd1, 8'h05); do_tick();
    io_rd(2'd1, d); chk("R3 low only", 16'(d), 16'h05);
    io_wr(2'd3, 8'h64); io_wr(2'd1, 8'h12); do_tick();
    io_rd(2'd1, d); chk("R3 high only", 16'(d), 16'h12);
    io_wr(2'd3, 8'h74); io_wr(2'd1, 8'h99);
    io_wr(2'd3, 8'h74); io_wr(2'd1, 8'h78); io_wr(2'd1, 8'h56); do_tick();
    rd16(2'd1, v); chk("R3 pointer reset", v, 16'h5678);
  endtask

  task automatic t_mode2();
    io_wr(2'd3, 8'h74);
    io_wr(2'd1, 8'h03); io_wr(2'd1, 8'h00);
    tick_seq("R11 rate wave", 1, 7, 16'b1101101);
    io_wr(2'd3, 8'h72);
    chk("R5 mode001 ignored", 16'(outs[1]), 16'h1);
    io_wr(2'd3, 8'hC0);
    tick_seq("R2 readback no-op", 1, 2, 16'b10);
  endtask

  task automatic t_fold();
    io_wr(2'd3, 8'hBC);
    io_wr(2'd2, 8'h03); io_wr(2'd2, 8'h00);
    tick_seq("R5 code110 as rate", 2, 4, 16'b1101);
    io_wr(2'd3, 8'hBE);
    io_wr(2'd2, 8'h04); io_wr(2'd2, 8'h00);
    tick_seq("R5 code111 as square", 2, 8, 16'b11001100);
  endtask

  task automatic t_mode3();
    io_wr(2'd3, 8'hB6);
    io_wr(2'd2, 8'h05); io_wr(2'd2, 8'h00);
    tick_seq("R12 odd square", 2, 10, 16'b1110011100);
  endtask

  task automatic t_mode4();
    io_wr(2'd3, 8'h38);
    chk("R10 cmd sets high", 16'(outs[0]), 16'h1);
    io_wr(2'd0, 8'h03); io_wr(2'd0, 8'h00);
    tick_seq("R13 strobe", 0, 6, 16'b111011);
    io_wr(2'd3, 8'h30);
    chk("R10 back to low", 16'(outs[0]), 16'h0);
  endtask

  task automatic t_bcd();
    logic [15:0] v;
    io_wr(2'd3, 8'h31);
    io_wr(2'd0, 8'h00); io_wr(2'd0, 8'h01);
    do_tick(); do_tick();
    rd16(2'd0, v); chk("R6 bcd borrow", v, 16'h0099);
    io_wr(2'd3, 8'h31);
    io_wr(2'd0, 8'h00); io_wr(2'd0, 8'h00);
    do_tick(); do_tick();
    rd16(2'd0, v); chk("R6 bcd zero max", v, 16'h9999);
    io_wr(2'd3, 8'h30);
    io_wr(2'd0, 8'h00); io_wr(2'd0, 8'h00);
    do_tick(); do_tick();
    rd16(2'd0, v); chk("R6 bin zero max", v, 16'hFFFF);
  endtask

  task automatic t_halt();
    logic [15:0] v;
    io_wr(2'd3, 8'h30);
    io_wr(2'd0, 8'h10); io_wr(2'd0, 8'h00);
    do_tick();
    h_en = 1'b1; h_req = 1'b1;
    repeat (3) do_tick();
    rd16(2'd0, v); chk("R8 halted count", v, 16'h0010);
    chk("R8 halted out", 16'(outs[0]), 16'h0);
    h_en = 1'b0;
    do_tick();
    rd16(2'd0, v); chk("R8 enable off", v, 16'h000F);
    h_en = 1'b1; h_req = 1'b0;
    do_tick();
    rd16(2'd0, v); chk("R8 request off", v, 16'h000E);
    h_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode0();
    t_load_wait();
    t_latch();
    t_bytes();
    t_mode2();
    t_fold();
    t_mode3();
    t_mode4();
    t_bcd();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule